// File: doc/BRIEF.md
# Multi-Channel Timer Register Front End

This block sits between a simple register bus and a set of two or three independent timer channels. It occupies a 48-byte (0x30) window. The window holds two shared registers and one register window for each channel. Every bus access is decoded to one of four targets: a shared register, one channel's window, or nothing. For a channel window, the block forwards the access with the offset made local to that channel, and it returns that channel's read data.

The shared start register holds one run bit per channel and drives a run line to each channel. An optional output-control register holds a single bit. Each channel's interrupt request is registered and brought out on a pin of its own. A constant per-channel flag tells each channel whether it carries the capture feature; only the third channel does. Accesses that reach no target read as zero, change nothing, and raise a one-cycle error pulse.

Top module: `tmr_unit`

## Requirements
- R1: While reset is applied and after it is released, `ch_run`, `out_ctrl`, `irq_out` and `bus_err` are all 0, and the start and output-control registers read back as 0.
- R2: A write to byte offset 0x04 stores the full 32-bit word. Bit i of that word drives `ch_run[i]`, visible after the write's clock edge. A read of 0x04 returns the stored word, and `ch_run` changes on no other access.
- R3: With `HAS_OCTL`=1, a write to offset 0x00 keeps only bit 0. That bit drives `out_ctrl`, and a read of 0x00 returns it zero-extended. With `HAS_OCTL`=0, offsets 0x00–0x03 are unmapped and `out_ctrl` stays 0.
- R4: Decode tests the channel bases from the highest down. Offsets 0x20–0x2F select channel 2, 0x14–0x1F select channel 1, and 0x08–0x13 select channel 0. `ch_sel` is one-hot with bit i for channel i. `ch_offs` is the offset minus the channel base, and `ch_wr`/`ch_wdata` follow the bus.
- R5: A read inside channel i's window returns bits [32i+31:32i] of `ch_rdata`.
- R6: Offsets 0x30–0x3F, offset 0x00 without the output-control register, and the channel 2 window in a two-channel build are unmapped. A read there returns 0. A write there changes no register. No `ch_sel` bit rises. `bus_err` is 1 for exactly the cycle after the access.
- R7: In a two-channel build, bit 2 of the start word drives no run line, yet it is still stored and read back.
- R8: `irq_out[i]` equals `ch_irq_in[i]` one clock later, for each channel independently.
- R9: `ch_capt_en[i]` is 1 only for i=2 in a three-channel build. It is 0 for every channel in a two-channel build.
- R10: While `bus_sel` is 0, no `ch_sel` bit is set, `bus_rdata` is 0 and no error pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset inside the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |
| bus_err | output | 1 | Pulse the cycle after an unmapped access |
| ch_sel | output | NUM_CH | One-hot channel select |
| ch_wr | output | 1 | Write strobe to the selected channel |
| ch_offs | output | 4 | Offset local to the selected channel |
| ch_wdata | output | DATA_W | Write data to channels |
| ch_rdata | input | NUM_CH*DATA_W | Packed channel read data, channel 0 lowest |
| ch_run | output | NUM_CH | Run enable per channel |
| ch_capt_en | output | NUM_CH | Capture feature flag per channel |
| ch_irq_in | input | NUM_CH | Interrupt request from each channel |
| irq_out | output | NUM_CH | Registered interrupt output per channel |
| out_ctrl | output | 1 | Output-control bit |

## Verification
The bench builds two instances side by side on one bus. The first has three channels with the output-control register. The second has two channels and no output-control register. Sweeping all 64 byte offsets through both instances covers every decode boundary. It also covers each channel base and end, the dropped third window, and the missing register at offset 0x00. The paired builds also show start bit 2 driving a run line in one instance and nothing in the other, and the capture flag present or absent.

// File: rtl/tmr_unit_pkg.sv
package tmr_unit_pkg;
  localparam int unsigned MAX_CH = 3;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned LOC_W  = 4;
  localparam int unsigned CHAN_W = 2;
  localparam logic [ADDR_W-1:0] WIN_END   = 6'h30;
  localparam logic [3:0]        START_WRD = 4'd1;
  localparam logic [3:0]        OCTL_WRD  = 4'd0;

  typedef enum logic [1:0] {
    RG_NONE  = 2'd0,
    RG_OCTL  = 2'd1,
    RG_START = 2'd2,
    RG_CHAN  = 2'd3
  } region_e;

  typedef struct packed {
    region_e           region;
    logic [CHAN_W-1:0] chan;
    logic [LOC_W-1:0]  loc;
  } dec_t;

  function automatic logic [ADDR_W-1:0] ch_base(input int idx);
    case (idx)
      0:       ch_base = 6'h08;
      1:       ch_base = 6'h14;
      default: ch_base = 6'h20;
    endcase
  endfunction
endpackage

// File: rtl/tmr_unit_decode.sv
module tmr_unit_decode
  import tmr_unit_pkg::*;
#(
  parameter int unsigned NUM_CH   = 3,
  parameter bit          HAS_OCTL = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  logic              hit;
  int                idx;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] diff;

  always_comb begin
    hit  = 1'b0;
    idx  = 0;
    for (int i = MAX_CH - 1; i >= 0; i--) begin
      if (!hit && (addr >= ch_base(i))) begin
        hit = 1'b1;
        idx = i;
      end
    end
    base = ch_base(idx);
    diff = addr - base;

    dec.region = RG_NONE;
    dec.chan   = '0;
    dec.loc    = '0;
    if (addr >= WIN_END) begin
      dec.region = RG_NONE;
    end else if (hit) begin
      if (idx < int'(NUM_CH)) begin
        dec.region = RG_CHAN;
        dec.chan   = CHAN_W'(idx);
        dec.loc    = LOC_W'(diff);
      end
    end else if (addr[5:2] == START_WRD) begin
      dec.region = RG_START;
    end else if (HAS_OCTL && (addr[5:2] == OCTL_WRD)) begin
      dec.region = RG_OCTL;
    end
  end
endmodule

// File: rtl/tmr_unit_shared.sv
module tmr_unit_shared #(
  parameter int unsigned DATA_W   = 32,
  parameter bit          HAS_OCTL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic              wr_octl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] start_q,
  output logic              octl_q
);
  logic [DATA_W-1:0] start_d;
  logic              start_en;

  always_comb begin
    start_en = wr_start;
    start_d  = start_q;
    if (start_en) start_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        start_q <= '0;
    else if (start_en) start_q <= start_d;
  end

  generate
    if (HAS_OCTL) begin : g_octl
      logic octl_d;
      logic octl_en;
      logic octl_r;
      always_comb begin
        octl_en = wr_octl;
        octl_d  = octl_r;
        if (octl_en) octl_d = wdata[0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       octl_r <= 1'b0;
        else if (octl_en) octl_r <= octl_d;
      end
      assign octl_q = octl_r;
    end else begin : g_no_octl
      assign octl_q = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tmr_unit_irq.sv
module tmr_unit_irq #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] irq_in,
  output logic [NUM_CH-1:0] irq_q
);
  generate
    for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_ch
      logic irq_d;
      always_comb irq_d = irq_in[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q[i] <= 1'b0;
        else        irq_q[i] <= irq_d;
      end
    end
  endgenerate
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_unit_pkg::*;
#(
  parameter int unsigned NUM_CH   = 3,
  parameter bit          HAS_OCTL = 1'b1,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic [5:0]               bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_err,
  output logic [NUM_CH-1:0]        ch_sel,
  output logic                     ch_wr,
  output logic [3:0]               ch_offs,
  output logic [DATA_W-1:0]        ch_wdata,
  input  logic [NUM_CH*DATA_W-1:0] ch_rdata,
  output logic [NUM_CH-1:0]        ch_run,
  output logic [NUM_CH-1:0]        ch_capt_en,
  input  logic [NUM_CH-1:0]        ch_irq_in,
  output logic [NUM_CH-1:0]        irq_out,
  output logic                     out_ctrl
);
  localparam int unsigned CAPT_CH = 2;

  logic rst_meta;
  logic rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  dec_t dec;

  tmr_unit_decode #(
    .NUM_CH  (NUM_CH),
    .HAS_OCTL(HAS_OCTL)
  ) u_decode (
    .addr(bus_addr),
    .dec (dec)
  );

  logic              wr_start;
  logic              wr_octl;
  logic [DATA_W-1:0] start_q;
  logic              octl_q;

  assign wr_start = bus_sel && bus_wr && (dec.region == RG_START);
  assign wr_octl  = bus_sel && bus_wr && (dec.region == RG_OCTL);

  tmr_unit_shared #(
    .DATA_W  (DATA_W),
    .HAS_OCTL(HAS_OCTL)
  ) u_shared (
    .clk     (clk),
    .rst_n   (rst_sync),
    .wr_start(wr_start),
    .wr_octl (wr_octl),
    .wdata   (bus_wdata),
    .start_q (start_q),
    .octl_q  (octl_q)
  );

  tmr_unit_irq #(
    .NUM_CH(NUM_CH)
  ) u_irq (
    .clk   (clk),
    .rst_n (rst_sync),
    .irq_in(ch_irq_in),
    .irq_q (irq_out)
  );

  logic ch_hit;
  assign ch_hit   = bus_sel && (dec.region == RG_CHAN);
  assign ch_wr    = ch_hit && bus_wr;
  assign ch_offs  = ch_hit ? dec.loc : '0;
  assign ch_wdata = bus_wdata;

  generate
    for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_chan
      assign ch_sel[i]     = ch_hit && (dec.chan == CHAN_W'(i));
      assign ch_run[i]     = start_q[i];
      assign ch_capt_en[i] = (i == int'(CAPT_CH));
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (dec.region)
        RG_OCTL:  bus_rdata = DATA_W'(octl_q);
        RG_START: bus_rdata = start_q;
        RG_CHAN: begin
          for (int i = 0; i < int'(NUM_CH); i++) begin
            if (dec.chan == CHAN_W'(i)) bus_rdata = ch_rdata[i*DATA_W +: DATA_W];
          end
        end
        default:  bus_rdata = '0;
      endcase
    end
  end

  logic err_d;
  logic err_q;

  always_comb err_d = bus_sel && (dec.region == RG_NONE);

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) err_q <= 1'b0;
    else           err_q <= err_d;
  end

  assign bus_err  = err_q;
  assign out_ctrl = octl_q;
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [5:0]        bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic [NUM_CH-1:0] ch_sel,
  input logic [NUM_CH-1:0] ch_run,
  input logic [NUM_CH-1:0] ch_irq_in,
  input logic [NUM_CH-1:0] irq_out
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (ch_sel == '0) && (bus_rdata == '0));

  assert_high_unmapped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && (bus_addr >= 6'h30)) |-> (ch_sel == '0) && (bus_rdata == '0));

  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(bus_sel && (bus_addr >= 6'h30))) |-> bus_err);

  assert_run_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(bus_sel && bus_wr && (bus_addr[5:2] == 4'd1))) |-> $stable(ch_run));

  assert_irq_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (irq_out == $past(ch_irq_in)));
endmodule

bind tmr_unit tmr_unit_chk #(
  .NUM_CH(NUM_CH),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .bus_err  (bus_err),
  .ch_sel   (ch_sel),
  .ch_run   (ch_run),
  .ch_irq_in(ch_irq_in),
  .irq_out  (irq_out)
);

// File: tb/tmr_unit_tb.sv
`timescale 1ns/1ps
module tmr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;

  logic [31:0] rd_a, rd_b;
  logic        err_a, err_b;
  logic [2:0]  sel_a, run_a, capt_a, irqin_a, irq_a;
  logic [1:0]  sel_b, run_b, capt_b, irqin_b, irq_b;
  logic        wr_a, wr_b, oc_a, oc_b;
  logic [3:0]  offs_a, offs_b;
  logic [31:0] wd_a, wd_b;
  logic [95:0] chrd_a;
  logic [63:0] chrd_b;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  tmr_unit #(.NUM_CH(3), .HAS_OCTL(1'b1), .DATA_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_a), .bus_err(err_a),
    .ch_sel(sel_a), .ch_wr(wr_a), .ch_offs(offs_a), .ch_wdata(wd_a),
    .ch_rdata(chrd_a), .ch_run(run_a), .ch_capt_en(capt_a),
    .ch_irq_in(irqin_a), .irq_out(irq_a), .out_ctrl(oc_a));

  tmr_unit #(.NUM_CH(2), .HAS_OCTL(1'b0), .DATA_W(32)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_b), .bus_err(err_b),
    .ch_sel(sel_b), .ch_wr(wr_b), .ch_offs(offs_b), .ch_wdata(wd_b),
    .ch_rdata(chrd_b), .ch_run(run_b), .ch_capt_en(capt_b),
    .ch_irq_in(irqin_b), .irq_out(irq_b), .out_ctrl(oc_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // -1 unmapped, 0..2 channel, 10 start, 11 output control
  function automatic int target(input int a, input int nch, input bit oc);
    if (a >= 48) return -1;
    if (a >= 32) return (nch == 3) ? 2 : -1;
    if (a >= 20) return 1;
    if (a >= 8)  return 0;
    if (a >= 4)  return 10;
    return oc ? 11 : -1;
  endfunction

  function automatic logic [31:0] pat(input int c);
    return 32'hC0DE_0000 | (32'h111 * (c + 1));
  endfunction

  task automatic acc(input logic wr, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    irqin_a = '0; irqin_b = '0;
    chrd_a = {pat(2), pat(1), pat(0)};
    chrd_b = {pat(1), pat(0)};
    repeat (3) @(negedge clk);
    chk("R1 run during reset", {29'b0, run_a}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 run a", {29'b0, run_a}, 32'h0);
    chk("R1 run b", {30'b0, run_b}, 32'h0);
    chk("R1 out_ctrl a", {31'b0, oc_a}, 32'h0);
    chk("R1 irq a", {29'b0, irq_a}, 32'h0);
    chk("R1 err", {30'b0, err_a, err_b}, 32'h0);

    // R10 idle bus
    bus_addr = 6'h08; #0.5;
    chk("R10 idle sel a", {29'b0, sel_a}, 32'h0);
    chk("R10 idle rdata a", rd_a, 32'h0);
    tick();
    chk("R10 idle no err", {31'b0, err_a}, 32'h0);

    // R4 R5 R6 sweep of all offsets, reads
    for (int a = 0; a < 64; a++) begin
      int ta, tb;
      logic [31:0] ea, eb;
      ta = target(a, 3, 1'b1);
      tb = target(a, 2, 1'b0);
      acc(1'b0, 6'(a), 32'h0);
      ea = (ta >= 0 && ta < 3) ? pat(ta) : 32'h0;  // shared regs are 0 here (R1)
      eb = (tb >= 0 && tb < 3) ? pat(tb) : 32'h0;
      chk($sformatf("R5 R6 rdata a @%0h", a), rd_a, ea);
      chk($sformatf("R5 R6 rdata b @%0h", a), rd_b, eb);
      chk($sformatf("R4 sel a @%0h", a), {29'b0, sel_a},
          (ta >= 0 && ta < 3) ? (32'h1 << ta) : 32'h0);
      chk($sformatf("R4 sel b @%0h", a), {30'b0, sel_b},
          (tb >= 0 && tb < 3) ? (32'h1 << tb) : 32'h0);
      if (ta >= 0 && ta < 3)
        chk($sformatf("R4 offs a @%0h", a), {28'b0, offs_a}, 32'(a - (8 + 12 * ta)));
      tick();
      chk($sformatf("R6 err a @%0h", a), {31'b0, err_a}, (ta < 0) ? 32'h1 : 32'h0);
      chk($sformatf("R6 err b @%0h", a), {31'b0, err_b}, (tb < 0) ? 32'h1 : 32'h0);
    end
    idle();
    tick();
    chk("R6 err single cycle", {30'b0, err_a, err_b}, 32'h0);

    // R2 start register
    acc(1'b1, 6'h04, 32'hA5A5_0005);
    tick();
    chk("R2 run a", {29'b0, run_a}, 32'h5);
    chk("R2 run b", {30'b0, run_b}, 32'h1);
    acc(1'b0, 6'h04, 32'h0);
    chk("R2 readback a", rd_a, 32'hA5A5_0005);
    chk("R2 readback b", rd_b, 32'hA5A5_0005);

    // R7 bit 2 in two-channel build
    acc(1'b1, 6'h04, 32'h4);
    tick();
    chk("R7 run a bit2", {29'b0, run_a}, 32'h4);
    chk("R7 run b unaffected", {30'b0, run_b}, 32'h0);
    acc(1'b0, 6'h04, 32'h0);
    chk("R7 readback b", rd_b, 32'h4);
    acc(1'b1, 6'h04, 32'h3);
    tick();
    chk("R2 run a 3", {29'b0, run_a}, 32'h3);
    chk("R2 run b 3", {30'b0, run_b}, 32'h3);

    // R3 output control
    acc(1'b1, 6'h00, 32'hFFFF_FFFF);
    tick();
    chk("R3 out_ctrl a", {31'b0, oc_a}, 32'h1);
    chk("R3 out_ctrl b absent", {31'b0, oc_b}, 32'h0);
    chk("R6 err b octl write", {31'b0, err_b}, 32'h1);
    chk("R3 err a none", {31'b0, err_a}, 32'h0);
    acc(1'b0, 6'h00, 32'h0);
    chk("R3 readback a", rd_a, 32'h1);
    chk("R3 readback b", rd_b, 32'h0);

    // R6 unmapped write leaves state
    acc(1'b1, 6'h30, 32'h0);
    chk("R6 no sel on write", {29'b0, sel_a}, 32'h0);
    tick();
    chk("R6 err write a", {31'b0, err_a}, 32'h1);
    chk("R6 run kept", {29'b0, run_a}, 32'h3);
    chk("R6 out_ctrl kept", {31'b0, oc_a}, 32'h1);
    acc(1'b0, 6'h04, 32'h0);
    chk("R6 start kept", rd_a, 32'h3);

    // R4 channel write forwarding
    acc(1'b1, 6'h24, 32'h1234_5678);
    chk("R4 wr sel a", {29'b0, sel_a}, 32'h4);
    chk("R4 wr strobe a", {31'b0, wr_a}, 32'h1);
    chk("R4 wr offs a", {28'b0, offs_a}, 32'h4);
    chk("R4 wdata a", wd_a, 32'h1234_5678);
    chk("R6 wr sel b none", {30'b0, sel_b}, 32'h0);
    chk("R6 wr strobe b", {31'b0, wr_b}, 32'h0);
    tick();
    chk("R6 err b ch2 write", {31'b0, err_b}, 32'h1);
    chk("R6 run b kept", {30'b0, run_b}, 32'h3);
    acc(1'b1, 6'h00, 32'h2);
    tick();
    chk("R3 only bit0", {31'b0, oc_a}, 32'h0);
    idle();

    // R8 interrupt routing
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      irqin_a = 3'(v);
      irqin_b = 2'(v ^ 3);
      #1;
      chk("R8 no early irq a", {29'b0, irq_a}, (v == 0) ? 32'h0 : 32'(v - 1));
      tick();
      chk("R8 irq a", {29'b0, irq_a}, 32'(v));
      chk("R8 irq b", {30'b0, irq_b}, 32'((v ^ 3) & 3));
    end

    // R9 capture flag
    chk("R9 capt a", {29'b0, capt_a}, 32'h4);
    chk("R9 capt b", {30'b0, capt_b}, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule